// File: doc/BRIEF.md
# Budgeted Linked-List DMA Walker

This block follows a chain of command packets kept in a word-addressed RAM and forwards each packet's payload to a device write port. Each packet opens with one 32-bit header word. The top 8 bits of the header hold the payload length in words. The low 24 bits hold the byte address of the next header, and bit 23 of that field marks the end of the chain. A start pulse loads the address of the first header. A level-sensitive channel request then lets the walk advance from one packet to the next.

The walker keeps a running count of the bus cycles it spends in the current slice. A header read costs one cycle. Each payload word costs `WORD_COST` cycles. Before every header read the count is compared with `SLICE_BUDGET`. Once the count has reached the budget, the walker keeps the next header address and backs off for `BACKOFF_CYCLES` cycles without touching the RAM. It then resumes where it stopped. A dropped channel request also parks the walk at the next header boundary. The completion flag rises only when a header carrying the end marker has been fully served.

Top module: `ll_dma_walker`

## Requirements
- R1: After a start pulse is sampled at an edge, the first header read goes out in the following cycle, provided the request is high. The header word address is bits `ADDR_W+1..2` of the 24-bit address field, so higher bits are ignored and the two low bits are dropped. Read data arrives one cycle after the read.
- R2: The payload words of a packet are read in the cycles right after its header data arrives, one word per cycle, from the consecutive word addresses that follow the header and wrap modulo 2^`ADDR_W`. Each word appears on the device port in the cycle after its read.
- R3: A header whose length field (bits 31..24) is zero produces no payload reads or device writes. The walker goes straight on to the next header in the following cycle.
- R4: When a header has bit 23 of its next field set, the walk ends after that packet's payload. `busy` falls and `done` rises on the same edge. `busy` stays high from launch until that edge.
- R5: Budget use starts at zero when a walk is launched. Each header read adds 1 and each payload word adds `WORD_COST`. The check is made only before a header read: if the use has reached `SLICE_BUDGET`, no read is issued and the walker halts.
- R6: A halt lasts exactly `BACKOFF_CYCLES` cycles with `halted` high and no RAM reads. After it, the budget use is cleared and the saved header is read.
- R7: While the request is low at a header boundary, no header is read and the budget use is cleared. A packet that has already started still finishes. When the request returns, the walk continues from the saved header.
- R8: A start pulse that arrives while the walker is busy is held, and the latest one wins. That walk launches in the first idle cycle after completion. Launching clears `done`.
- R9: After reset, `busy`, `done`, `halted`, `ram_rd_en` and `dev_wr_en` are all low.
- R10: `done` stays low during a halt and while the walk is parked by the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse |
| start_addr | input | 24 | Byte address of the first header |
| req | input | 1 | Channel request gating each header step |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_addr | output | ADDR_W | RAM word address |
| ram_rd_data | input | 32 | RAM data, one cycle after the read |
| dev_wr_en | output | 1 | Device write strobe |
| dev_wr_data | output | 32 | Payload word to the device |
| busy | output | 1 | Walk in progress |
| halted | output | 1 | Back-off in progress |
| done | output | 1 | Chain finished; cleared on the next launch |

## Verification
The hardest situation to reach is the budget halt. With the default budget, the walker only halts after more than a thousand cycles of uninterrupted traffic, and the halt must land exactly on a header boundary with the saved address intact. The stimulus reaches it with a six-packet chain of full 255-word packets. Four packets use 1024 cycles of budget, so the fifth header check trips the halt. The chain then finishes in a second slice. A cycle-level behavioural model predicts every RAM read and device write across that halt. The model also covers a request drop in the middle of a packet and a start that arrives while the walker is busy.

// File: rtl/ll_dma_walker.sv
module ll_dma_walker #(
  parameter int ADDR_W = 12,
  parameter int SLICE_BUDGET = 1000,
  parameter int BACKOFF_CYCLES = 100,
  parameter int WORD_COST = 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [23:0]       start_addr,
  input  logic              req,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic [31:0]       ram_rd_data,
  output logic              dev_wr_en,
  output logic [31:0]       dev_wr_data,
  output logic              busy,
  output logic              halted,
  output logic              done
);
  localparam int UW = $clog2(SLICE_BUDGET + 256 * WORD_COST + 2);
  localparam int TW = $clog2(BACKOFF_CYCLES + 2);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_HWAIT, S_PAY, S_HALT, S_FIN} st_t;

  st_t               st;
  logic [ADDR_W-1:0] hdr_a, pay_a;
  logic [7:0]        left;
  logic [23:0]       nxt_f, pend_f;
  logic              pend, wr_q, done_q;
  logic [UW-1:0]     used;
  logic [TW-1:0]     tmr;

  function automatic logic [ADDR_W-1:0] waddr(input logic [23:0] f);
    return f[ADDR_W+1:2];
  endfunction

  wire over   = used >= UW'(SLICE_BUDGET);
  wire hdr_go = (st == S_HDR) && req && !over;

  assign ram_rd_en   = hdr_go || (st == S_PAY);
  assign ram_addr    = (st == S_PAY) ? pay_a : hdr_a;
  assign dev_wr_en   = wr_q;
  assign dev_wr_data = wr_q ? ram_rd_data : 32'h0;
  assign busy        = st != S_IDLE;
  assign halted      = st == S_HALT;
  assign done        = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      hdr_a  <= '0;
      pay_a  <= '0;
      left   <= '0;
      nxt_f  <= '0;
      pend_f <= '0;
      pend   <= 1'b0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      used   <= '0;
      tmr    <= '0;
    end else begin
      wr_q <= st == S_PAY;
      if (st != S_IDLE && start) begin
        pend   <= 1'b1;
        pend_f <= start_addr;
      end
      case (st)
        S_IDLE: if (start || pend) begin
          hdr_a  <= waddr(start ? start_addr : pend_f);
          pend   <= 1'b0;
          used   <= '0;
          done_q <= 1'b0;
          st     <= S_HDR;
        end
        S_HDR: begin
          if (!req) used <= '0;
          else if (over) begin
            tmr <= TW'(BACKOFF_CYCLES - 1);
            st  <= S_HALT;
          end else begin
            used <= used + UW'(1);
            st   <= S_HWAIT;
          end
        end
        S_HWAIT: begin
          nxt_f <= ram_rd_data[23:0];
          left  <= ram_rd_data[31:24];
          pay_a <= hdr_a + ADDR_W'(1);
          if (ram_rd_data[31:24] != 8'd0) st <= S_PAY;
          else if (ram_rd_data[23]) st <= S_FIN;
          else begin
            hdr_a <= waddr(ram_rd_data[23:0]);
            st    <= S_HDR;
          end
        end
        S_PAY: begin
          used  <= used + UW'(WORD_COST);
          pay_a <= pay_a + ADDR_W'(1);
          left  <= left - 8'd1;
          if (left == 8'd1) begin
            if (nxt_f[23]) st <= S_FIN;
            else begin
              hdr_a <= waddr(nxt_f);
              st    <= S_HDR;
            end
          end
        end
        S_HALT: begin
          if (tmr == '0) begin
            used <= '0;
            st   <= S_HDR;
          end else tmr <= tmr - TW'(1);
        end
        S_FIN: begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ll_dma_walker_chk.sv
module ll_dma_walker_chk #(
  parameter int BACKOFF_CYCLES = 100
)(
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic ram_rd_en,
  input logic dev_wr_en,
  input logic busy,
  input logic halted,
  input logic done
);
  int hcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt <= 0;
    else if (halted) hcnt <= hcnt + 1;
    else hcnt <= 0;
  end

  assert_no_read_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !ram_rd_en);
  assert_halt_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |-> hcnt == BACKOFF_CYCLES);
  assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ram_rd_en && !dev_wr_en));
  assert_no_done_in_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !done);
  assert_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind ll_dma_walker ll_dma_walker_chk #(.BACKOFF_CYCLES(BACKOFF_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ram_rd_en(ram_rd_en),
  .dev_wr_en(dev_wr_en), .busy(busy), .halted(halted), .done(done)
);

// File: tb/tb_ll_dma_walker.sv
`timescale 1ns/1ps
module tb_ll_dma_walker;
  localparam int AW = 12;
  localparam int DEPTH = 1 << AW;
  localparam int MASK = DEPTH - 1;
  localparam int BUDGET = 1000;
  localparam int BACKOFF = 100;
  localparam int COST = 1;

  logic clk = 0, rst_n = 0, start = 0, req = 1;
  logic [23:0] start_addr = '0;
  logic ram_rd_en, dev_wr_en, busy, halted, done;
  logic [AW-1:0] ram_addr;
  logic [31:0] ram_q = '0, dev_wr_data;
  logic [31:0] mem [0:DEPTH-1];

  always #5 clk = ~clk;

  ll_dma_walker #(.ADDR_W(AW), .SLICE_BUDGET(BUDGET), .BACKOFF_CYCLES(BACKOFF),
                  .WORD_COST(COST)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .req(req),
    .ram_rd_en(ram_rd_en), .ram_addr(ram_addr), .ram_rd_data(ram_q),
    .dev_wr_en(dev_wr_en), .dev_wr_data(dev_wr_data),
    .busy(busy), .halted(halted), .done(done));

  always @(posedge clk) if (ram_rd_en) ram_q <= mem[ram_addr];

  int checks = 0, errs = 0;
  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit e_rd = 0, e_wr = 0, e_busy = 0, e_halt = 0, e_done = 0, model_on = 0;
  int e_addr = 0;
  logic [31:0] e_wd = '0, carry_d = '0;
  bit carry = 0, ls = 0, pend = 0;
  logic [23:0] la = '0, pa = '0;

  task nxt();
    bit was_busy;
    was_busy = e_busy;
    @(posedge clk);
    ls = start;
    la = start_addr;
    if (ls && was_busy) begin pend = 1; pa = la; end
    #3;
    e_wr = carry; e_wd = carry_d; carry = 0; e_rd = 0;
  endtask

  initial begin
    int word, used, pw;
    bit lp;
    logic [31:0] h;
    @(posedge rst_n);
    model_on = 1;
    forever begin
      e_busy = 0;
      do begin lp = pend; nxt(); end while (!(ls || lp));
      word = ((ls ? int'(la) : int'(pa)) >> 2) & MASK;
      pend = 0; e_done = 0; e_busy = 1; used = 0;
      forever begin
        if (!req) begin used = 0; nxt(); continue; end
        if (used >= BUDGET) begin
          nxt(); e_halt = 1;
          repeat (BACKOFF) nxt();
          e_halt = 0; used = 0;
          continue;
        end
        e_rd = 1; e_addr = word; used += 1; nxt();
        h = mem[word]; nxt();
        pw = word + 1;
        for (int i = 0; i < int'(h[31:24]); i++) begin
          pw &= MASK;
          e_rd = 1; e_addr = pw; carry = 1; carry_d = mem[pw];
          used += COST; pw++;
          nxt();
        end
        if (h[23]) begin nxt(); e_done = 1; e_busy = 0; break; end
        word = (int'(h[23:0]) >> 2) & MASK;
      end
    end
  end

  always @(negedge clk) if (model_on && rst_n) begin
    check("R1 ram_rd_en", ram_rd_en, e_rd);
    if (e_rd) check("R1 ram_addr", ram_addr, e_addr);
    check("R2 dev_wr_en", dev_wr_en, e_wr);
    if (e_wr) check("R2 dev_wr_data", dev_wr_data, e_wd);
    check("R4 busy", busy, e_busy);
    check("R10 done", done, e_done);
    check("R6 halted", halted, e_halt);
  end

  // monitors
  int n_rd, n_wr, n_hlt, n_rise, n_pre, n_dih, n_win;
  bit prev_done = 0, seen_halt = 0, win = 0;
  task clr();
    n_rd = 0; n_wr = 0; n_hlt = 0; n_rise = 0; n_pre = 0; n_dih = 0; n_win = 0;
    seen_halt = 0;
  endtask
  always @(negedge clk) if (rst_n) begin
    if (ram_rd_en) n_rd++;
    if (dev_wr_en) n_wr++;
    if (halted) begin n_hlt++; seen_halt = 1; end
    if (ram_rd_en && !seen_halt) n_pre++;
    if (halted && done) n_dih++;
    if (win && ram_rd_en) n_win++;
    if (done && !prev_done) n_rise++;
    prev_done = done;
  end

  task go(input logic [23:0] a);
    @(posedge clk); #2; start = 1; start_addr = a;
    @(posedge clk); #2; start = 0;
  endtask

  task wait_rises(input int n);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (n_rise >= n) break;
    end
    check("R4 completion seen", n_rise >= n, 1);
    repeat (3) @(negedge clk);
  endtask

  task finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; errs++;
    $display("FAIL R4 watchdog: actual busy %0d expected 0", busy);
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 32'h5A000000 | i;
    // chain A: 2 words, zero-length node, 3 words, end
    mem[2200] = {8'd2, 24'(2210 * 4)};
    mem[2210] = {8'd0, 24'(2220 * 4)};
    mem[2220] = {8'd3, 24'h800000};
    // chain B: six full packets
    for (int k = 0; k < 6; k++) begin
      int w;
      w = 512 + 256 * k;
      mem[w] = {8'd255, (k == 5) ? 24'h800000 : 24'((w + 256) * 4)};
    end
    // chain C: payload wraps past the top of RAM
    mem[4094] = {8'd3, 24'h800000};
    // chain D: three 4-word packets
    mem[2300] = {8'd4, 24'(2310 * 4)};
    mem[2310] = {8'd4, 24'(2320 * 4)};
    mem[2320] = {8'd4, 24'h800000};

    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R9: reset state
    check("R9 busy", busy, 0);
    check("R9 done", done, 0);
    check("R9 halted", halted, 0);
    check("R9 ram_rd_en", ram_rd_en, 0);
    check("R9 dev_wr_en", dev_wr_en, 0);

    // chain A, high address bits must be ignored (R1)
    clr();
    go(24'h400000 | 24'(2200 * 4));
    wait_rises(1);
    check("R2 chain A writes", n_wr, 5);
    check("R3 chain A reads", n_rd, 8);
    check("R4 chain A done", done, 1);

    // chain B: budget halt
    clr();
    go(24'(512 * 4));
    wait_rises(1);
    check("R5 reads before halt", n_pre, 1024);
    check("R6 halt cycles", n_hlt, BACKOFF);
    check("R2 chain B writes", n_wr, 1530);
    check("R10 done during halt", n_dih, 0);

    // chain C: wrap
    clr();
    go(24'(4094 * 4));
    wait_rises(1);
    check("R2 wrap writes", n_wr, 3);

    // chain D: request drop mid-packet
    clr();
    go(24'(2300 * 4));
    repeat (3) @(posedge clk);
    #2 req = 0;
    repeat (10) @(negedge clk);
    win = 1;
    repeat (30) @(negedge clk);
    win = 0;
    check("R7 reads while parked", n_win, 0);
    check("R7 busy while parked", busy, 1);
    check("R10 done while parked", done, 0);
    @(posedge clk); #2 req = 1;
    wait_rises(1);
    check("R7 writes after resume", n_wr, 12);

    // pending start
    clr();
    go(24'(2200 * 4));
    repeat (4) @(posedge clk);
    go(24'(2300 * 4));
    wait_rises(2);
    check("R8 completions", n_rise, 2);
    check("R8 total writes", n_wr, 17);
    check("R8 done after second", done, 1);

    finish_run();
  end
endmodule